// File: doc/BRIEF.md
# Deterministic Commit Store Buffer

This block sits beside one core and keeps every store the core makes during the parallel phase of a quantum private. Stores land in a small fully associative buffer instead of shared memory, so no other core can observe them. The owning core still sees its own writes: a load looks in the buffer first and falls back to a memory read port on a miss. A store to an address that is already held replaces that entry's data, so each address occupies at most one slot.

When the quantum ends, a commit command moves the block into a commit phase. It then waits for an external turn token. While the token is high it publishes one held entry per cycle on a memory write port. Entries leave in slot order, which is the order in which their addresses were first stored. This gives every core the same write sequence for a given program. A one-cycle done pulse marks the moment the buffer is empty. If a store arrives for a new address while every slot is occupied, the block raises a trap and drops the store rather than stalling.

For a context switch, a save command streams all held entries out, marks the final one, and empties the buffer. A restore command clears the buffer and rebuilds it from the same stream, fed back in.

Top module: `commit_store_buffer`

## Requirements
- R1: After reset the buffer is empty, `busy`, `done`, `full_trap`, `dump_valid` and `mem_wr_en` are low. While `busy` is low, `mem_wr_en` stays low, so an accepted store is never written to memory outside a commit.
- R2: A `commit_req` seen while idle raises `busy` from the next cycle. While `commit_grant` is low nothing is written. While it is high, one entry per cycle appears on `mem_wr_en`/`mem_wr_addr`/`mem_wr_data`, in the order in which the addresses were first stored, and each written entry is freed.
- R3: In the commit phase, with `commit_grant` high and no entry left, `done` is high for exactly one cycle. `busy` is low in the following cycle. A commit of an empty buffer writes nothing and only pulses `done` once granted.
- R4: With `ld_valid` high and `ld_addr` held in the buffer, `ld_hit` is 1 and `ld_data` is that entry's data in the same cycle, and `mem_rd_en` is 0. On a miss, `ld_hit` is 0, `mem_rd_en` is 1, `mem_rd_addr` equals `ld_addr`, and `ld_data` equals `mem_rd_data`.
- R5: A store to an address already in the buffer replaces that entry's data and takes no new slot. Its position in commit order is unchanged.
- R6: The buffer holds DEPTH entries (16 by default). A store to an address that is not held, made while all entries are valid, sets `full_trap` in that cycle and is discarded. A store to a held address never traps.
- R7: A `save_req` seen while idle streams every held entry on `dump_valid`/`dump_addr`/`dump_data`, one per cycle, in commit order, starting the next cycle. `dump_last` is set on the final entry only. The buffer is empty afterwards, and `done` pulses in the cycle after the last entry, or in the first cycle if the buffer was empty.
- R8: A `restore_req` seen while idle clears the buffer and keeps `busy` high while `rs_valid` words are loaded into consecutive slots. The word with `rs_last` set ends the restore. The restored entries then answer loads and commit in stream order.
- R9: Stores presented while `busy` is high are ignored. They never trap and are absent from the buffer afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request from the core |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| full_trap | output | 1 | Store dropped: buffer full and address not held |
| ld_valid | input | 1 | Load request from the core |
| ld_addr | input | AW | Load address |
| ld_hit | output | 1 | Load answered from the buffer |
| ld_data | output | DW | Load result (buffer or memory) |
| mem_rd_en | output | 1 | Memory read request on a load miss |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | DW | Memory read data, same cycle |
| commit_req | input | 1 | Start the commit phase |
| commit_grant | input | 1 | Turn token: publishing allowed |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_data | output | DW | Memory write data |
| save_req | input | 1 | Start streaming the contents out |
| dump_valid | output | 1 | Saved entry valid |
| dump_addr | output | AW | Saved entry address |
| dump_data | output | DW | Saved entry data |
| dump_last | output | 1 | Final saved entry |
| restore_req | input | 1 | Start rebuilding from a stream |
| rs_valid | input | 1 | Restore word valid |
| rs_addr | input | AW | Restore word address |
| rs_data | input | DW | Restore word data |
| rs_last | input | 1 | Final restore word |
| busy | output | 1 | Commit, save or restore in progress |
| done | output | 1 | One-cycle pulse: commit or save finished empty |

## Verification
A stale valid bit shows up in the same cycle as a wrong `ld_hit`. It also appears as an extra or missing write during the next commit, caught at the write port in the cycle it is due. A wrong slot order or a lost overwrite shows as a mismatched address or data on `mem_wr_*` or `dump_*` in the exact cycle of that entry. A miscounted occupancy surfaces as `full_trap` firing one store early or late, or as `done` arriving a cycle away from the expected drain length.

// File: rtl/csb_pkg.sv
package csb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMT  = 2'd1,
    ST_SAVE = 2'd2,
    ST_RST  = 2'd3
  } csb_state_e;
endpackage

// File: rtl/csb_pick.sv
// Lowest-index selector over a request vector.
module csb_pick #(
  parameter int N = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic          single
);
  function automatic logic [IW-1:0] lowest(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  always_comb begin
    found  = |req;
    idx    = lowest(req);
    single = ($countones(req) == 1);
  end
endmodule

// File: rtl/csb_match.sv
// Associative address lookup over all slots.
module csb_match #(
  parameter int DEPTH = 16,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0]         valid,
  input  logic [DEPTH-1:0][AW-1:0] tab_addr,
  input  logic [DEPTH-1:0][DW-1:0] tab_data,
  input  logic [AW-1:0]            key,
  output logic                     hit,
  output logic [IW-1:0]            hit_idx,
  output logic [DW-1:0]            hit_data
);
  logic [DEPTH-1:0] eq;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign eq[g] = valid[g] && (tab_addr[g] == key);
  end

  always_comb begin
    hit      = |eq;
    hit_idx  = '0;
    hit_data = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit_idx  = IW'(i);
        hit_data = tab_data[i];
      end
    end
  end
endmodule

// File: rtl/commit_store_buffer.sv
module commit_store_buffer #(
  parameter int DEPTH = 16,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          full_trap,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data,
  input  logic          commit_req,
  input  logic          commit_grant,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  input  logic          save_req,
  output logic          dump_valid,
  output logic [AW-1:0] dump_addr,
  output logic [DW-1:0] dump_data,
  output logic          dump_last,
  input  logic          restore_req,
  input  logic          rs_valid,
  input  logic [AW-1:0] rs_addr,
  input  logic [DW-1:0] rs_data,
  input  logic          rs_last,
  output logic          busy,
  output logic          done
);
  import csb_pkg::*;

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OW = $clog2(DEPTH + 1);
  localparam int PW = IW + 1;

  function automatic logic [OW-1:0] occ_of(input logic [DEPTH-1:0] v);
    return OW'($countones(v));
  endfunction

  csb_state_e state_q, state_d;
  logic [DEPTH-1:0]         valid_q;
  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][DW-1:0] data_q;
  logic [PW-1:0]            rs_ptr_q;

  // Named internal events
  logic          st_hit, st_take, st_upd, st_alloc;
  logic [IW-1:0] st_hit_idx;
  logic [DW-1:0] st_hit_data;
  logic          ld_match;
  logic [IW-1:0] ld_idx;
  logic [DW-1:0] ld_fwd;
  logic          free_found, free_single;
  logic [IW-1:0] free_idx;
  logic          head_found, head_single;
  logic [IW-1:0] head_idx;
  logic          drain_fire, save_fire, rs_fire, rs_enter;
  logic [OW-1:0] occupancy;

  csb_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_st_match (
    .valid(valid_q), .tab_addr(addr_q), .tab_data(data_q), .key(st_addr),
    .hit(st_hit), .hit_idx(st_hit_idx), .hit_data(st_hit_data)
  );

  csb_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_ld_match (
    .valid(valid_q), .tab_addr(addr_q), .tab_data(data_q), .key(ld_addr),
    .hit(ld_match), .hit_idx(ld_idx), .hit_data(ld_fwd)
  );

  csb_pick #(.N(DEPTH)) u_free_pick (
    .req(~valid_q), .found(free_found), .idx(free_idx), .single(free_single)
  );

  csb_pick #(.N(DEPTH)) u_head_pick (
    .req(valid_q), .found(head_found), .idx(head_idx), .single(head_single)
  );

  assign occupancy  = occ_of(valid_q);

  assign st_take    = st_valid && (state_q == ST_IDLE);
  assign st_upd     = st_take && st_hit;
  assign st_alloc   = st_take && !st_hit && free_found;
  assign full_trap  = st_take && !st_hit && !free_found;

  assign ld_hit      = ld_valid && ld_match;
  assign mem_rd_en   = ld_valid && !ld_match;
  assign mem_rd_addr = ld_addr;
  assign ld_data     = ld_match ? ld_fwd : mem_rd_data;

  assign drain_fire  = (state_q == ST_CMT) && commit_grant && head_found;
  assign save_fire   = (state_q == ST_SAVE) && head_found;
  assign rs_fire     = (state_q == ST_RST) && rs_valid && (rs_ptr_q < PW'(DEPTH));
  assign rs_enter    = (state_q == ST_IDLE) && (state_d == ST_RST);

  assign mem_wr_en   = drain_fire;
  assign mem_wr_addr = addr_q[head_idx];
  assign mem_wr_data = data_q[head_idx];

  assign dump_valid  = save_fire;
  assign dump_addr   = addr_q[head_idx];
  assign dump_data   = data_q[head_idx];
  assign dump_last   = save_fire && head_single;

  assign done = ((state_q == ST_CMT) && commit_grant && !head_found) ||
                ((state_q == ST_SAVE) && !head_found);
  assign busy = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (commit_req)       state_d = ST_CMT;
        else if (save_req)    state_d = ST_SAVE;
        else if (restore_req) state_d = ST_RST;
      end
      ST_CMT:  if (done) state_d = ST_IDLE;
      ST_SAVE: if (done) state_d = ST_IDLE;
      ST_RST:  if (rs_valid && rs_last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      valid_q  <= '0;
      rs_ptr_q <= '0;
    end else begin
      state_q <= state_d;
      if (st_alloc) valid_q[free_idx] <= 1'b1;
      if (drain_fire || save_fire) valid_q[head_idx] <= 1'b0;
      if (rs_enter) begin
        valid_q  <= '0;
        rs_ptr_q <= '0;
      end
      if (rs_fire) begin
        valid_q[rs_ptr_q[IW-1:0]] <= 1'b1;
        rs_ptr_q <= rs_ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st_upd) data_q[st_hit_idx] <= st_data;
    if (st_alloc) begin
      addr_q[free_idx] <= st_addr;
      data_q[free_idx] <= st_data;
    end
    if (rs_fire) begin
      addr_q[rs_ptr_q[IW-1:0]] <= rs_addr;
      data_q[rs_ptr_q[IW-1:0]] <= rs_data;
    end
  end
endmodule

// File: rtl/csb_checker.sv
module csb_checker #(
  parameter int DEPTH = 16,
  localparam int OW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          mem_wr_en,
  input logic          commit_grant,
  input logic          full_trap,
  input logic          ld_hit,
  input logic          mem_rd_en,
  input logic          dump_valid,
  input logic          dump_last,
  input logic [OW-1:0] occupancy
);
  p_no_publish_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_wr_en);

  p_publish_on_token_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> commit_grant);

  p_drain_frees_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> (occupancy == OW'($past(occupancy) - 1'b1)));

  p_done_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (occupancy == '0));

  p_done_then_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_forward_no_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit |-> !mem_rd_en);

  p_trap_only_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full_trap |-> (occupancy == OW'(DEPTH)));

  p_trap_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full_trap |=> (occupancy == $past(occupancy)));

  p_last_is_final_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dump_valid && dump_last) |-> (occupancy == OW'(1)));

  p_no_trap_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !full_trap);
endmodule

bind commit_store_buffer csb_checker #(.DEPTH(DEPTH)) u_csb_checker (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .mem_wr_en(mem_wr_en), .commit_grant(commit_grant), .full_trap(full_trap),
  .ld_hit(ld_hit), .mem_rd_en(mem_rd_en), .dump_valid(dump_valid),
  .dump_last(dump_last), .occupancy(occupancy)
);

// File: tb/test_commit_store_buffer.sv
module test_commit_store_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_valid = 0, ld_valid = 0, commit_req = 0, commit_grant = 0;
  logic save_req = 0, restore_req = 0, rs_valid = 0, rs_last = 0;
  logic [31:0] st_addr = 0, st_data = 0, ld_addr = 0, rs_addr = 0, rs_data = 0;
  logic full_trap, ld_hit, mem_rd_en, mem_wr_en, dump_valid, dump_last, busy, done;
  logic [31:0] ld_data, mem_rd_addr, mem_rd_data, mem_wr_addr, mem_wr_data;
  logic [31:0] dump_addr, dump_data;

  int vectors = 0;
  int miscmp = 0;

  // Bench model: addresses in first-store order
  logic [31:0] m_a [DEPTH];
  logic [31:0] m_d [DEPTH];
  int m_n = 0;
  logic [31:0] sv_a [DEPTH];
  logic [31:0] sv_d [DEPTH];
  int sv_n = 0;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return a ^ 32'h5A5A_0F0F;
  endfunction

  assign mem_rd_data = memf(mem_rd_addr);

  always #(CLK_PERIOD / 2) clk = ~clk;

  commit_store_buffer #(.DEPTH(DEPTH), .AW(32), .DW(32)) i_commit_store_buffer (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .full_trap(full_trap),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .commit_req(commit_req), .commit_grant(commit_grant),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .save_req(save_req), .dump_valid(dump_valid), .dump_addr(dump_addr),
    .dump_data(dump_data), .dump_last(dump_last),
    .restore_req(restore_req), .rs_valid(rs_valid), .rs_addr(rs_addr),
    .rs_data(rs_data), .rs_last(rs_last), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscmp++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int m_find(input logic [31:0] a);
    for (int i = 0; i < m_n; i++) if (m_a[i] == a) return i;
    return -1;
  endfunction

  task automatic do_store(input logic [31:0] a, input logic [31:0] d);
    int k;
    bit exp_trap;
    k = m_find(a);
    exp_trap = (k < 0) && (m_n == DEPTH);
    st_valid = 1; st_addr = a; st_data = d;
    #1;
    chk(full_trap == exp_trap, "R6 trap on store", 32'(full_trap), 32'(exp_trap));
    tick();
    st_valid = 0;
    if (k >= 0) m_d[k] = d;
    else if (!exp_trap) begin m_a[m_n] = a; m_d[m_n] = d; m_n++; end
  endtask

  task automatic do_load(input logic [31:0] a);
    int k;
    k = m_find(a);
    ld_valid = 1; ld_addr = a;
    #1;
    if (k >= 0) begin
      chk(ld_hit && !mem_rd_en, "R4 hit flags", {ld_hit, mem_rd_en}, 32'h2);
      chk(ld_data == m_d[k], "R4 forwarded data", ld_data, m_d[k]);
    end else begin
      chk(!ld_hit && mem_rd_en && mem_rd_addr == a, "R4 miss flags",
          {ld_hit, mem_rd_en}, 32'h1);
      chk(ld_data == memf(a), "R4 memory data", ld_data, memf(a));
    end
    tick();
    ld_valid = 0;
  endtask

  task automatic do_commit(input int hold_cycles);
    commit_req = 1;
    tick();
    commit_req = 0;
    for (int c = 0; c < hold_cycles; c++) begin
      #1;
      chk(busy && !mem_wr_en && !done, "R2 waits for token",
          {busy, mem_wr_en, done}, 32'h4);
      tick();
    end
    commit_grant = 1;
    for (int i = 0; i <= m_n; i++) begin
      #1;
      if (i < m_n) begin
        chk(mem_wr_en && !done, "R2 write strobe", {mem_wr_en, done}, 32'h2);
        chk(mem_wr_addr == m_a[i], "R2 write order addr", mem_wr_addr, m_a[i]);
        chk(mem_wr_data == m_d[i], "R5 write data", mem_wr_data, m_d[i]);
      end else begin
        chk(done && !mem_wr_en, "R3 done pulse", {done, mem_wr_en}, 32'h2);
      end
      tick();
    end
    commit_grant = 0;
    #1;
    chk(!busy && !done, "R3 idle after done", {busy, done}, 32'h0);
    m_n = 0;
  endtask

  task automatic t_reset();
    #1;
    chk(!busy && !done && !full_trap && !dump_valid && !mem_wr_en, "R1 reset outputs",
        {busy, done, full_trap, dump_valid, mem_wr_en}, 32'h0);
    do_load(32'h0000_0040);
  endtask

  task automatic t_forward_overwrite();
    do_store(32'h1000, 32'hAAAA_0001);
    do_store(32'h2000, 32'hAAAA_0002);
    do_store(32'h3000, 32'hAAAA_0003);
    #1;
    chk(!mem_wr_en && !busy, "R1 no publish in parallel phase", 32'(mem_wr_en), 32'h0);
    do_load(32'h2000);
    do_load(32'h9000);
    do_store(32'h1000, 32'hBBBB_0001); // R5 overwrite keeps slot 0
    do_load(32'h1000);
    chk(m_n == 3, "R5 no duplicate slot", 32'(m_n), 32'd3);
    do_commit(3);
    do_load(32'h1000);
  endtask

  task automatic t_empty_commit();
    do_commit(1); // R3 empty buffer: done only, no write
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) do_store(32'h4000 + 32'(i * 4), 32'hC000_0000 + 32'(i));
    do_store(32'h8888, 32'hDEAD_BEEF); // R6 traps
    do_load(32'h8888);
    do_store(32'h4008, 32'hC0DE_0002); // R6 held address: no trap
    do_load(32'h4008);
    do_commit(0);
  endtask

  task automatic t_busy_ignore();
    do_store(32'h5000, 32'h5555_0000);
    commit_req = 1;
    tick();
    commit_req = 0;
    st_valid = 1; st_addr = 32'h6000; st_data = 32'h6666_0000;
    #1;
    chk(!full_trap && busy, "R9 store while busy", {full_trap, busy}, 32'h1);
    tick();
    st_valid = 0;
    commit_grant = 1;
    #1;
    chk(mem_wr_en && mem_wr_addr == 32'h5000, "R9 only held entry drains",
        mem_wr_addr, 32'h5000);
    tick();
    #1;
    chk(done && !mem_wr_en, "R9 ignored store not published", {done, mem_wr_en}, 32'h2);
    tick();
    commit_grant = 0;
    m_n = 0;
    do_load(32'h6000);
  endtask

  task automatic do_save();
    save_req = 1;
    tick();
    save_req = 0;
    sv_n = m_n;
    for (int i = 0; i <= sv_n; i++) begin
      #1;
      if (i < sv_n) begin
        chk(dump_valid && dump_addr == m_a[i], "R7 dump addr", dump_addr, m_a[i]);
        chk(dump_data == m_d[i], "R7 dump data", dump_data, m_d[i]);
        chk(dump_last == (i == sv_n - 1), "R7 last flag", 32'(dump_last),
            32'(i == sv_n - 1));
        sv_a[i] = dump_addr; sv_d[i] = dump_data;
      end else begin
        chk(done && !dump_valid, "R7 done after stream", {done, dump_valid}, 32'h2);
      end
      tick();
    end
    m_n = 0;
  endtask

  task automatic do_restore();
    restore_req = 1;
    tick();
    restore_req = 0;
    for (int i = 0; i < sv_n; i++) begin
      rs_valid = 1; rs_addr = sv_a[i]; rs_data = sv_d[i]; rs_last = (i == sv_n - 1);
      #1;
      chk(busy, "R8 busy while restoring", 32'(busy), 32'h1);
      tick();
    end
    rs_valid = 0; rs_last = 0;
    #1;
    chk(!busy, "R8 idle after last word", 32'(busy), 32'h0);
    for (int i = 0; i < sv_n; i++) begin m_a[i] = sv_a[i]; m_d[i] = sv_d[i]; end
    m_n = sv_n;
  endtask

  task automatic t_save_restore();
    do_store(32'h7000, 32'h7777_0000);
    do_store(32'h7100, 32'h7777_0001);
    do_store(32'h7200, 32'h7777_0002);
    do_save();
    do_load(32'h7100); // R7 cleared: must miss
    do_store(32'h7300, 32'h7777_0003); // junk cleared by restore
    do_restore();
    do_load(32'h7300);
    do_load(32'h7200);
    do_commit(2); // R8 restored order commits
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_forward_overwrite();
    t_empty_commit();
    t_full();
    t_busy_ignore();
    t_save_restore();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    miscmp++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule